// File: doc/BRIEF.md
# UART Receive Break Detector

This block sits between a UART receive deserializer and the receive FIFO. For every completed frame it decides whether the byte is handed on to the FIFO. It also watches the sampled receive line to recognise a break. A break is a frame that ends with a framing error while the line is still at space (0) a fixed number of clock cycles after the frame completes.

When a break is recognised, a sticky status flag is raised. The block then stops passing frames to the FIFO. The frame that triggered the detection has already been passed on. The hold is released once the line has been seen at mark (1): the next completed frame is stored again and normal operation continues. The hold and the sticky flag are kept in separate state, so software clearing the flag does not end the hold.

Software clears the flag by reading it while it is 1 and then writing 0. A standby input clears the flag, the hold and any pending break check. An interrupt request is the flag gated by an enable input.

Top module: `rx_break_gate`

## Requirements
- R1: After reset, `brk_flag_o`, `brk_irq_o` and `fifo_wr_o` are 0 and frames are accepted.
- R2: A frame accepted on the clock edge where `frame_done_i` is 1 raises `fifo_wr_o` for exactly the following cycle. In that cycle `fifo_data_o` and `fifo_ferr_o` carry that frame's data and framing-error bit.
- R3: An accepted frame with `frame_ferr_i`=1 starts a check. If `rx_line_i` is 0 on the clock edge exactly SETTLE_CYC edges after the frame edge, and no new accepted frame or standby occurs on that edge, the flag becomes 1 after that edge.
- R4: If `rx_line_i` is 1 on that check edge, neither the flag nor the hold is set.
- R5: The frame that started a successful break check is still written to the FIFO.
- R6: While the hold is active and the line has not yet been seen at mark, completed frames are dropped: there is no `fifo_wr_o` and no new break check starts.
- R7: Once `rx_line_i`=1 has been sampled on an edge during the hold, the next completed frame is written to the FIFO and the hold ends.
- R8: With CLR_NEEDS_READ=1, the flag clears only when `stat_wr_i` with `stat_wdata_i`=0 follows a `stat_rd_i` taken while the flag was 1. Any write consumes that read. Writes of 1, and writes of 0 without a prior read, leave the flag unchanged. A break detection on the same edge wins over the clear.
- R9: Clearing the flag by software does not end the hold; frames stay dropped until R7 applies.
- R10: `standby_i`=1 on an edge clears the flag, the hold, the pending check and the pending read, and suppresses any FIFO write on that edge.
- R11: `brk_irq_o` equals `brk_flag_o` AND `irq_en_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Standby: clears flag, hold and pending check |
| frame_done_i | input | 1 | One-cycle strobe: a frame completed |
| frame_data_i | input | DATA_W | Data of the completed frame |
| frame_ferr_i | input | 1 | Framing error of the completed frame |
| rx_line_i | input | 1 | Sampled receive line level (1 = mark) |
| stat_rd_i | input | 1 | Status read strobe |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 1 | Value written to the flag |
| irq_en_i | input | 1 | Receive interrupt enable |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DATA_W | Data to the FIFO |
| fifo_ferr_o | output | 1 | Framing-error bit stored with the data |
| brk_flag_o | output | 1 | Sticky break flag (status read value) |
| brk_irq_o | output | 1 | Break interrupt request |

## Verification
A wrong check counter shows up as the flag rising a cycle early or late, or not at all, on the edge SETTLE_CYC after a framing-error frame. A wrong hold state shows at `fifo_wr_o`: it is either missing or present on the cycle after the first frame following a break or a mark. A flag or read-pending bit that is left set or cleared by mistake appears at `brk_flag_o` and `brk_irq_o` the cycle after the offending access. The bench compares every port against a reference model on every cycle, so any divergence is reported within one cycle of reaching the ports.

// File: rtl/brk_pkg.sv
package brk_pkg;
   typedef enum logic [1:0] {
      GATE_PASS  = 2'd0,
      GATE_HOLD  = 2'd1,
      GATE_ARMED = 2'd2
   } gate_st_t;
endpackage

// File: rtl/brk_detect.sv
module brk_detect #(
   parameter int SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic standby_i,
   input  logic take_i,
   input  logic ferr_i,
   input  logic line_i,
   output logic detect_o
);
   localparam int CNT_W = $clog2(SETTLE_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (standby_i)
         cnt_q <= '0;
      else if (take_i)
         cnt_q <= ferr_i ? LOAD : '0;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - LAST;
   end

   assign detect_o = (cnt_q == LAST) && !line_i && !take_i && !standby_i;

   // R3
   ck_detect_after_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && ferr_i && !standby_i) |=> (cnt_q == LOAD));
endmodule

// File: rtl/brk_gate.sv
module brk_gate
   import brk_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_i,
   input  logic              frame_done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ferr_i,
   input  logic              line_i,
   input  logic              detect_i,
   output logic              take_o,
   output logic              hold_o,
   output logic              fifo_wr_o,
   output logic [DATA_W-1:0] fifo_data_o,
   output logic              fifo_ferr_o
);
   gate_st_t st_q, st_d;

   assign take_o = frame_done_i && (st_q != GATE_HOLD) && !standby_i;
   assign hold_o = (st_q != GATE_PASS);

   always_comb begin
      st_d = st_q;
      if (standby_i)
         st_d = GATE_PASS;
      else if (detect_i)
         st_d = GATE_HOLD;
      else begin
         unique case (st_q)
            GATE_HOLD:  if (line_i) st_d = GATE_ARMED;
            GATE_ARMED: if (frame_done_i) st_d = GATE_PASS;
            default:    st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= GATE_PASS;
         fifo_wr_o   <= 1'b0;
         fifo_data_o <= '0;
         fifo_ferr_o <= 1'b0;
      end else begin
         st_q      <= st_d;
         fifo_wr_o <= take_o;
         if (take_o) begin
            fifo_data_o <= data_i;
            fifo_ferr_o <= ferr_i;
         end
      end
   end

   // R6
   drop_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == GATE_HOLD && frame_done_i) |=> !fifo_wr_o);

   // R7
   resume_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == GATE_ARMED && frame_done_i && !standby_i && !detect_i) |=> (fifo_wr_o && !hold_o));
endmodule

// File: rtl/brk_flag.sv
module brk_flag #(
   parameter bit CLR_NEEDS_READ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic standby_i,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic flag_o
);
   logic flag_q;
   logic clr_ok;

   generate
      if (CLR_NEEDS_READ) begin : g_rd_wr
         logic rd_seen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rd_seen_q <= 1'b0;
            else if (standby_i || wr_i)
               rd_seen_q <= 1'b0;
            else if (rd_i && flag_q)
               rd_seen_q <= 1'b1;
         end
         assign clr_ok = wr_i && !wdata_i && rd_seen_q;
      end else begin : g_wr_only
         logic unused_rd;
         assign unused_rd = rd_i;
         assign clr_ok    = wr_i && !wdata_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (standby_i)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr_ok)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R8
   clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(flag_q) && !$past(standby_i)) |-> ($past(wr_i) && !$past(wdata_i)));

   // R10
   standby_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby_i |=> !flag_q);
endmodule

// File: rtl/rx_break_gate.sv
module rx_break_gate #(
   parameter int DATA_W         = 8,
   parameter int SETTLE_CYC     = 4,
   parameter bit CLR_NEEDS_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_i,
   input  logic              frame_done_i,
   input  logic [DATA_W-1:0] frame_data_i,
   input  logic              frame_ferr_i,
   input  logic              rx_line_i,
   input  logic              stat_rd_i,
   input  logic              stat_wr_i,
   input  logic              stat_wdata_i,
   input  logic              irq_en_i,
   output logic              fifo_wr_o,
   output logic [DATA_W-1:0] fifo_data_o,
   output logic              fifo_ferr_o,
   output logic              brk_flag_o,
   output logic              brk_irq_o
);
   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (SETTLE_CYC >= 1) else $error("SETTLE_CYC must be at least 1");
   end

   logic take;
   logic hold;
   logic detect;

   brk_detect #(.SETTLE_CYC(SETTLE_CYC)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .standby_i(standby_i),
      .take_i   (take),
      .ferr_i   (frame_ferr_i),
      .line_i   (rx_line_i),
      .detect_o (detect)
   );

   brk_gate #(.DATA_W(DATA_W)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .standby_i   (standby_i),
      .frame_done_i(frame_done_i),
      .data_i      (frame_data_i),
      .ferr_i      (frame_ferr_i),
      .line_i      (rx_line_i),
      .detect_i    (detect),
      .take_o      (take),
      .hold_o      (hold),
      .fifo_wr_o   (fifo_wr_o),
      .fifo_data_o (fifo_data_o),
      .fifo_ferr_o (fifo_ferr_o)
   );

   brk_flag #(.CLR_NEEDS_READ(CLR_NEEDS_READ)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .standby_i(standby_i),
      .set_i    (detect),
      .rd_i     (stat_rd_i),
      .wr_i     (stat_wr_i),
      .wdata_i  (stat_wdata_i),
      .flag_o   (brk_flag_o)
   );

   assign brk_irq_o = brk_flag_o & irq_en_i;

   // R2
   write_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_o |-> $past(frame_done_i));

   // R3
   flag_needs_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_flag_o) |-> (!$past(rx_line_i) && hold));

   // R10
   standby_ends_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      standby_i |=> (!hold && !fifo_wr_o));
endmodule

// File: tb/rx_break_gate_bench.sv
module rx_break_gate_bench;
   localparam int SETTLE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       standby_i = 1'b0;
   logic       frame_done_i = 1'b0;
   logic [7:0] frame_data_i = '0;
   logic       frame_ferr_i = 1'b0;
   logic       rx_line_i = 1'b1;
   logic       stat_rd_i = 1'b0;
   logic       stat_wr_i = 1'b0;
   logic       stat_wdata_i = 1'b0;
   logic       irq_en_i = 1'b0;
   logic       fifo_wr_o;
   logic [7:0] fifo_data_o;
   logic       fifo_ferr_o;
   logic       brk_flag_o;
   logic       brk_irq_o;

   always #10 clk = ~clk;

   rx_break_gate #(.DATA_W(8), .SETTLE_CYC(SETTLE), .CLR_NEEDS_READ(1'b1)) u_rx_break_gate (
      .clk, .rst_n, .standby_i, .frame_done_i, .frame_data_i, .frame_ferr_i,
      .rx_line_i, .stat_rd_i, .stat_wr_i, .stat_wdata_i, .irq_en_i,
      .fifo_wr_o, .fifo_data_o, .fifo_ferr_o, .brk_flag_o, .brk_irq_o
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state (0 pass, 1 hold, 2 armed)
   bit       m_flag, m_rds, m_wr, m_fe;
   int       m_gate, m_cnt;
   bit [7:0] m_data;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit take, det;
      take = frame_done_i && (m_gate != 1) && !standby_i;
      det  = (m_cnt == 1) && !rx_line_i && !take && !standby_i;
      m_wr = take;
      if (take) begin
         m_data = frame_data_i;
         m_fe   = frame_ferr_i;
      end
      if (standby_i) begin
         m_flag = 0; m_rds = 0; m_gate = 0; m_cnt = 0;
      end else begin
         if (det) m_flag = 1;
         else if (stat_wr_i && !stat_wdata_i && m_rds) m_flag = 0;
         if (stat_wr_i) m_rds = 0;
         else if (stat_rd_i && m_flag && !det) m_rds = 1;
         else if (stat_rd_i && det) m_rds = m_rds;
         if (det) m_gate = 1;
         else if (m_gate == 1 && rx_line_i) m_gate = 2;
         else if (m_gate == 2 && frame_done_i) m_gate = 0;
         if (take) m_cnt = frame_ferr_i ? SETTLE : 0;
         else if (m_cnt != 0) m_cnt--;
      end
   endtask

   // read-pending uses flag value before the edge: fix ordering
   task automatic model_step_ordered();
      bit old_flag;
      old_flag = m_flag;
      model_step();
      if (!standby_i && !stat_wr_i) m_rds = m_rds | (stat_rd_i && old_flag);
   endtask

   task automatic compare();
      chk("R2 fifo_wr", int'(fifo_wr_o), int'(m_wr));
      if (m_wr) begin
         chk("R2 fifo_data", int'(fifo_data_o), int'(m_data));
         chk("R2 fifo_ferr", int'(fifo_ferr_o), int'(m_fe));
      end
      chk("R3 flag", int'(brk_flag_o), int'(m_flag));
      chk("R11 irq", int'(brk_irq_o), int'(m_flag & irq_en_i));
   endtask

   task automatic cyc(input bit fd, input bit [7:0] d, input bit fe, input bit ln,
                      input bit rd = 0, input bit wr = 0, input bit wd = 0, input bit sb = 0);
      frame_done_i = fd; frame_data_i = d; frame_ferr_i = fe; rx_line_i = ln;
      stat_rd_i = rd; stat_wr_i = wr; stat_wdata_i = wd; standby_i = sb;
      model_step_ordered();
      @(negedge clk);
      compare();
   endtask

   task automatic do_break(input bit [7:0] d);
      cyc(1, d, 1, 0);
      for (int i = 0; i < SETTLE; i++) cyc(0, 0, 0, 0);
   endtask

   initial begin
      #4000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      bit ln;
      void'($urandom(32'h5eed_0042));
      m_flag = 0; m_rds = 0; m_wr = 0; m_fe = 0; m_gate = 0; m_cnt = 0; m_data = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 flag", int'(brk_flag_o), 0);
      chk("R1 irq", int'(brk_irq_o), 0);
      chk("R1 fifo_wr", int'(fifo_wr_o), 0);

      // R2 plain frame
      cyc(1, 8'hA5, 0, 1);
      chk("R2 write", int'(fifo_wr_o), 1);
      chk("R2 data", int'(fifo_data_o), 8'hA5);
      cyc(0, 0, 0, 1);
      chk("R2 single pulse", int'(fifo_wr_o), 0);

      // R4 framing error with line at mark
      cyc(1, 8'h00, 1, 1);
      chk("R4 ferr stored", int'(fifo_ferr_o), 1);
      for (int i = 0; i < SETTLE; i++) cyc(0, 0, 0, 1);
      chk("R4 no flag", int'(brk_flag_o), 0);
      cyc(1, 8'h11, 0, 1);
      chk("R4 no hold", int'(fifo_wr_o), 1);

      // R3 / R5 break, with timing edge
      irq_en_i = 1'b1;
      cyc(1, 8'h00, 1, 0);
      chk("R5 break frame written", int'(fifo_wr_o), 1);
      chk("R5 break frame data", int'(fifo_data_o), 0);
      for (int i = 0; i < SETTLE - 1; i++) cyc(0, 0, 0, 0);
      chk("R3 not early", int'(brk_flag_o), 0);
      cyc(0, 0, 0, 0);
      chk("R3 flag set", int'(brk_flag_o), 1);
      chk("R11 irq on", int'(brk_irq_o), 1);
      irq_en_i = 1'b0;
      #1;
      chk("R11 irq masked", int'(brk_irq_o), 0);

      // R6 dropped frames during hold
      cyc(1, 8'h00, 1, 0);
      chk("R6 dropped", int'(fifo_wr_o), 0);

      // R8 clear and R9 hold persists
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk("R8 cleared", int'(brk_flag_o), 0);
      cyc(1, 8'h00, 0, 0);
      chk("R9 still dropped", int'(fifo_wr_o), 0);

      // R7 resume after mark
      cyc(0, 0, 0, 1);
      cyc(1, 8'h3C, 0, 1);
      chk("R7 resumed", int'(fifo_wr_o), 1);
      chk("R7 data", int'(fifo_data_o), 8'h3C);
      cyc(1, 8'h5A, 0, 1);
      chk("R7 stays open", int'(fifo_wr_o), 1);

      // R8 ignored writes
      do_break(8'h00);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk("R8 write0 w/o read", int'(brk_flag_o), 1);
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 1, 1);
      chk("R8 write1 ignored", int'(brk_flag_o), 1);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk("R8 read consumed", int'(brk_flag_o), 1);

      // R10 standby
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      chk("R10 flag cleared", int'(brk_flag_o), 0);
      cyc(1, 8'h77, 0, 0);
      chk("R10 hold cleared", int'(fifo_wr_o), 1);

      // random phase
      ln = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         bit fd, fe, rd, wr, wd, sb;
         if ($urandom_range(0, 3) == 0) ln = ~ln;
         fd = ($urandom_range(0, 4) == 0);
         fe = ($urandom_range(0, 2) == 0);
         rd = ($urandom_range(0, 9) == 0);
         wr = ($urandom_range(0, 11) == 0);
         wd = ($urandom_range(0, 3) == 0);
         sb = ($urandom_range(0, 399) == 0);
         if ($urandom_range(0, 49) == 0) irq_en_i = ~irq_en_i;
         cyc(fd, fe ? 8'h00 : 8'($urandom), fe, ln, rd, wr, wd, sb);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule